// File: doc/BRIEF.md
# Dual Regulator Start-Up Sequencer

This controller brings up two voltage regulator channels that share one set of bias circuits. Two asynchronous enable requests, one per channel, are resynchronised and then drive a state machine. Once any request is present, the machine waits for the supply comparator to report a healthy input. It then pulses a strobe that captures trim settings. Next it powers the shared bias phases one after another: bandgap, reference, current generator and bypass precharge. Each phase moves on only when its done flag arrives. When all phases are up, the channels are allowed to ramp.

Channel 1 always has precedence. Channel 2 may be held back until output 1 is in regulation. Whether it is held depends on how the arrival of enable 1 relates to the ramp state of channel 2. A supply dip below the lower threshold shuts everything off. When the supply is good again, the whole bring-up repeats. A phase whose done flag never comes is abandoned after a bounded wait, and the supply check runs again.

Top module: `dual_rail_sequencer`

## Requirements
- R1: While both synchronised enables are low, the phase enables, the trim strobe and both ramp enables are all low.
- R2: After an enable is raised, nothing starts while `supply_hi_i` is low.
- R3: Bring-up begins with a trim strobe exactly one cycle wide. The phase enables then turn on cumulatively in index order: bit 0 bandgap, bit 1 reference, bit 2 current generator, bit 3 bypass precharge. Bit k rises only in the cycle after `phase_done_i[k-1]` was seen high.
- R4: No ramp enable is asserted until every phase enable is on.
- R5: If channel 1 is enabled while channel 2's ramp enable is not yet latched as started, channel 2's ramp enable stays low until `ch1_in_reg_i` is high. This covers the cases where both enables arrive together, where enable 2 arrives after enable 1, and where enable 2 was first.
- R6: If enable 2 arrives first and enable 1 follows before `ch2_ramping_i` was seen, channel 2's ramp enable is withdrawn and channel 1 ramps alone until `ch1_in_reg_i` rises.
- R7: If channel 2 has been seen ramping (its ramp enable and `ch2_ramping_i` both high at a clock edge), a later enable 1 turns on channel 1 at once and leaves channel 2 running.
- R8: With both enables raised in the same cycle, channel 1's ramp enable is asserted first.
- R9: `supply_lo_i` high at a clock edge clears every phase and ramp enable by the next cycle. Once `supply_hi_i` returns, the full sequence reruns, starting with a new trim strobe.
- R10: If a phase's done flag is missing for TIMEOUT_CYC cycles, all phase enables drop in the next cycle. With the supply good, a new trim strobe follows one cycle later.
- R11: Dropping one channel's enable clears only that channel's ramp enable. The phase enables stay on while the other enable is high.
- R12: An enable change reaches the ramp enables after exactly two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rail_en_i | input | 2 | Asynchronous enable requests, bit 0 channel 1, bit 1 channel 2 |
| supply_hi_i | input | 1 | Supply above upper undervoltage threshold |
| supply_lo_i | input | 1 | Supply below lower undervoltage threshold |
| phase_done_i | input | NUM_PHASES | Per-phase settled flags |
| ch2_ramping_i | input | 1 | Channel 2 output ramp has begun |
| ch1_in_reg_i | input | 1 | Channel 1 output has reached its target |
| trim_strobe_o | output | 1 | One-cycle trim capture strobe |
| phase_en_o | output | NUM_PHASES | Cumulative bias phase enables |
| ramp_en_o | output | 2 | Ramp permission, bit 0 channel 1, bit 1 channel 2 |

## Verification
The bench covers each arrival order of the two enables against channel 2's ramp state.
- A design that latched channel 2's permission too early would let channel 2 keep ramping when enable 1 arrives before the ramp starts.
- A design that never latched it would cut channel 2 off once it is already ramping.

It also checks the supply dip in the middle of operation and the phase timeout, which would otherwise leave stale phase enables on or skip the re-strobe of trim. The two-edge synchroniser delay is sampled cycle by cycle, so a missing or extra stage shows up.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
   typedef enum logic [2:0] {
      SQ_OFF,
      SQ_UVCHK,
      SQ_TRIM,
      SQ_PHASE,
      SQ_READY
   } seq_state_e;
endpackage

// File: rtl/pwrseq_sync.sv
module pwrseq_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   initial assert (STAGES >= 2) else $error("pwrseq_sync: STAGES below 2");

   logic [WIDTH-1:0] pipe [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk_i or negedge rst_ni)
            if (!rst_ni) pipe[0] <= '0;
            else         pipe[0] <= d_i;
      end else begin : g_next
         always_ff @(posedge clk_i or negedge rst_ni)
            if (!rst_ni) pipe[s] <= '0;
            else         pipe[s] <= pipe[s-1];
      end
   end

   assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/pwrseq_phase_fsm.sv
module pwrseq_phase_fsm
   import pwrseq_pkg::*;
#(
   parameter int NUM_PHASES  = 4,
   parameter int TIMEOUT_CYC = 4096
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  en_any_i,
   input  logic                  supply_hi_i,
   input  logic                  supply_lo_i,
   input  logic [NUM_PHASES-1:0] phase_done_i,
   output logic                  trim_strobe_o,
   output logic [NUM_PHASES-1:0] phase_en_o,
   output logic                  ready_o
);
   localparam int IDX_W = (NUM_PHASES > 1) ? $clog2(NUM_PHASES) : 1;
   localparam int CNT_W = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC) : 1;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_PHASES - 1);
   localparam logic [CNT_W-1:0] CNT_LIM  = CNT_W'(TIMEOUT_CYC - 1);

   initial assert (NUM_PHASES >= 2) else $error("pwrseq_phase_fsm: NUM_PHASES below 2");
   initial assert (TIMEOUT_CYC >= 2) else $error("pwrseq_phase_fsm: TIMEOUT_CYC below 2");

   seq_state_e       state;
   logic [IDX_W-1:0] idx;
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state <= SQ_OFF;
         idx   <= '0;
         cnt   <= '0;
      end else if (!en_any_i) begin
         state <= SQ_OFF;
         idx   <= '0;
         cnt   <= '0;
      end else if (supply_lo_i) begin
         state <= SQ_UVCHK;
         idx   <= '0;
         cnt   <= '0;
      end else begin
         case (state)
            SQ_OFF:   state <= SQ_UVCHK;
            SQ_UVCHK: if (supply_hi_i) state <= SQ_TRIM;
            SQ_TRIM: begin
               state <= SQ_PHASE;
               idx   <= '0;
               cnt   <= '0;
            end
            SQ_PHASE: begin
               if (phase_done_i[idx]) begin
                  cnt <= '0;
                  if (idx == LAST_IDX) state <= SQ_READY;
                  else                 idx   <= idx + 1'b1;
               end else if (cnt == CNT_LIM) begin
                  state <= SQ_UVCHK;
                  idx   <= '0;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            SQ_READY: state <= SQ_READY;
            default:  state <= SQ_OFF;
         endcase
      end
   end

   for (genvar k = 0; k < NUM_PHASES; k++) begin : g_phase_en
      assign phase_en_o[k] = (state == SQ_READY) ||
                             ((state == SQ_PHASE) && (idx >= IDX_W'(k)));
   end

   assign trim_strobe_o = (state == SQ_TRIM);
   assign ready_o       = (state == SQ_READY);

   // R3: strobe lasts one cycle
   p_strobe_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      trim_strobe_o |=> !trim_strobe_o);

   // R3: each later phase waits for its predecessor's done flag
   for (genvar k = 1; k < NUM_PHASES; k++) begin : g_order_chk
      p_phase_order_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
         $rose(phase_en_o[k]) |-> $past(phase_done_i[k-1]));
   end
endmodule

// File: rtl/pwrseq_ramp_arb.sv
module pwrseq_ramp_arb (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       ready_i,
   input  logic [1:0] en_i,
   input  logic       ch2_ramping_i,
   input  logic       ch1_in_reg_i,
   output logic [1:0] ramp_en_o
);
   logic ch2_locked;

   // channel 2 keeps its grant once it has been seen ramping
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                     ch2_locked <= 1'b0;
      else if (!ready_i || !en_i[1])   ch2_locked <= 1'b0;
      else if (ramp_en_o[1] && ch2_ramping_i) ch2_locked <= 1'b1;
   end

   assign ramp_en_o[0] = ready_i && en_i[0];
   assign ramp_en_o[1] = ready_i && en_i[1] &&
                         (ch2_locked || !en_i[0] || ch1_in_reg_i);

   // R5: a fresh channel 2 grant beside an active channel 1 needs output 1 settled
   p_ch2_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(ramp_en_o[1]) && en_i[0]) |-> ch1_in_reg_i);
endmodule

// File: rtl/dual_rail_sequencer.sv
module dual_rail_sequencer #(
   parameter int NUM_PHASES  = 4,
   parameter int TIMEOUT_CYC = 4096,
   parameter int SYNC_STAGES = 2
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic [1:0]            rail_en_i,
   input  logic                  supply_hi_i,
   input  logic                  supply_lo_i,
   input  logic [NUM_PHASES-1:0] phase_done_i,
   input  logic                  ch2_ramping_i,
   input  logic                  ch1_in_reg_i,
   output logic                  trim_strobe_o,
   output logic [NUM_PHASES-1:0] phase_en_o,
   output logic [1:0]            ramp_en_o
);
   logic [1:0] en_s;
   logic       ready;

   pwrseq_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (rail_en_i),
      .q_o   (en_s)
   );

   pwrseq_phase_fsm #(.NUM_PHASES(NUM_PHASES), .TIMEOUT_CYC(TIMEOUT_CYC)) u_fsm (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .en_any_i     (|en_s),
      .supply_hi_i  (supply_hi_i),
      .supply_lo_i  (supply_lo_i),
      .phase_done_i (phase_done_i),
      .trim_strobe_o(trim_strobe_o),
      .phase_en_o   (phase_en_o),
      .ready_o      (ready)
   );

   pwrseq_ramp_arb u_arb (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .ready_i      (ready),
      .en_i         (en_s),
      .ch2_ramping_i(ch2_ramping_i),
      .ch1_in_reg_i (ch1_in_reg_i),
      .ramp_en_o    (ramp_en_o)
   );

   // R1: both requests gone means a fully quiet controller next cycle
   p_off_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_s == 2'b00) |=> (phase_en_o == '0 && ramp_en_o == 2'b00 && !trim_strobe_o));

   // R9: undervoltage removes everything next cycle
   p_uv_drop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      supply_lo_i |=> (phase_en_o == '0 && ramp_en_o == 2'b00));

   // R4: ramps only with all bias phases up
   p_ramp_gated_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ramp_en_o != 2'b00) |-> (&phase_en_o));
endmodule

// File: tb/dual_rail_sequencer_tb_top.sv
module dual_rail_sequencer_tb_top;
   localparam int NP = 4;
   localparam int TO = 20;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [1:0]    en;
   logic          sup_hi, sup_lo;
   logic [NP-1:0] done;
   logic          ch2_ramping, ch1_in_reg;
   logic          trim;
   logic [NP-1:0] phase_en;
   logic [1:0]    ramp;

   int n_chk  = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   dual_rail_sequencer #(.NUM_PHASES(NP), .TIMEOUT_CYC(TO), .SYNC_STAGES(2)) dut_i (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .rail_en_i    (en),
      .supply_hi_i  (sup_hi),
      .supply_lo_i  (sup_lo),
      .phase_done_i (done),
      .ch2_ramping_i(ch2_ramping),
      .ch1_in_reg_i (ch1_in_reg),
      .trim_strobe_o(trim),
      .phase_en_o   (phase_en),
      .ramp_en_o    (ramp)
   );

   function automatic logic [NP-1:0] thermo(input int n);
      return NP'((1 << n) - 1);
   endfunction

   // expected ramp enables with no ramp-started latch in play
   function automatic logic [1:0] exp_ramp(input logic [1:0] e, input logic inreg);
      return {e[1] && (!e[0] || inreg), e[0]};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic clear_flags();
      done = '0; ch2_ramping = 1'b0; ch1_in_reg = 1'b0;
   endtask

   task automatic go_off();
      en = 2'b00;
      repeat (3) @(negedge clk);
      chk("R1 off", {phase_en, ramp, trim}, '0);
      clear_flags();
   endtask

   task automatic bring_up(input logic [1:0] exp_final, input string tag);
      int w = 0;
      while (!trim && w < 50) begin @(negedge clk); w++; end
      chk("R3 strobe seen", 32'(trim), 1);
      @(negedge clk);
      chk("R3 strobe width", 32'(trim), 0);
      for (int k = 0; k < NP; k++) begin
         w = 0;
         while (!phase_en[k] && w < 50) begin @(negedge clk); w++; end
         chk("R3 phase order", 32'(phase_en), 32'(thermo(k + 1)));
         chk("R4 no early ramp", 32'(ramp), 0);
         repeat ($urandom % 3) @(negedge clk);
         done[k] = 1'b1;
      end
      @(negedge clk);
      chk(tag, 32'(ramp), 32'(exp_final));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_0042));
      rst_n = 1'b0; en = 2'b00; sup_hi = 1'b0; sup_lo = 1'b0;
      clear_flags();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset", {phase_en, ramp, trim}, '0);

      // R2: wait for healthy supply
      en = 2'b01;
      repeat (10) @(negedge clk);
      chk("R2 held phases", 32'(phase_en), 0);
      chk("R2 held strobe", 32'(trim), 0);
      sup_hi = 1'b1;
      bring_up(2'b01, "R4 ch1 ramp");

      // R5: enable 2 after enable 1, output 1 not settled
      en = 2'b11;
      repeat (8) @(negedge clk);
      chk("R5 ch2 held", 32'(ramp), 32'b01);
      ch1_in_reg = 1'b1;
      #1 chk("R5 ch2 released", 32'(ramp), 32'b11);
      ch2_ramping = 1'b1;
      @(negedge clk);

      // R12 / R11: drop channel 1
      en = 2'b10;
      @(negedge clk);
      chk("R12 one edge", 32'(ramp), 32'b11);
      @(negedge clk);
      chk("R12 two edges", 32'(ramp), 32'b10);
      chk("R11 phases kept", 32'(phase_en), 32'(thermo(NP)));
      go_off();

      // R6: enable 2 first, enable 1 before ramp started
      en = 2'b10;
      bring_up(2'b10, "R6 ch2 alone");
      en = 2'b11;
      repeat (2) @(negedge clk);
      chk("R6 ch2 withdrawn", 32'(ramp), 32'b01);
      repeat (5) @(negedge clk);
      chk("R6 ch2 waits", 32'(ramp), 32'b01);
      ch1_in_reg = 1'b1;
      #1 chk("R6 ch2 resumes", 32'(ramp), 32'b11);
      go_off();

      // R7: enable 2 ramping, then enable 1
      en = 2'b10;
      bring_up(2'b10, "R7 ch2 alone");
      ch2_ramping = 1'b1;
      @(negedge clk);
      en = 2'b11;
      repeat (2) @(negedge clk);
      chk("R7 both run", 32'(ramp), 32'b11);
      go_off();

      // R8: simultaneous enables
      en = 2'b11;
      bring_up(2'b01, "R8 ch1 first");
      repeat (5) @(negedge clk);
      chk("R8 ch2 still held", 32'(ramp), 32'b01);
      ch1_in_reg = 1'b1;
      #1 chk("R8 ch2 follows", 32'(ramp), 32'b11);

      // R9: undervoltage in operation and recovery
      @(negedge clk);
      sup_lo = 1'b1; sup_hi = 1'b0;
      @(negedge clk);
      chk("R9 ramps off", 32'(ramp), 0);
      chk("R9 phases off", 32'(phase_en), 0);
      clear_flags();
      sup_lo = 1'b0;
      repeat (5) @(negedge clk);
      chk("R9 waits supply", 32'(phase_en), 0);
      sup_hi = 1'b1;
      bring_up(2'b01, "R9 rerun");
      go_off();

      // R10: missing done flag
      en = 2'b01;
      begin
         int w = 0;
         while (!phase_en[0] && w < 50) begin @(negedge clk); w++; end
         done[0] = 1'b1;
         w = 0;
         while (!phase_en[1] && w < 50) begin @(negedge clk); w++; end
      end
      repeat (TO - 1) @(negedge clk);
      chk("R10 last wait cycle", 32'(phase_en), 32'(thermo(2)));
      @(negedge clk);
      chk("R10 abandoned", 32'(phase_en), 0);
      @(negedge clk);
      chk("R10 re-strobe", 32'(trim), 1);
      go_off();

      // random mix of enables and output-1 status
      en = 2'b01;
      bring_up(2'b01, "R4 random start");
      for (int i = 0; i < 40; i++) begin
         logic [1:0] ne;
         logic       ir;
         ne = 2'($urandom % 4);
         if (ne == 2'b00) ne = 2'b11;
         ir = 1'($urandom % 2);
         en = ne; ch1_in_reg = ir;
         repeat (3) @(negedge clk);
         if (ne == 2'b11) chk("R5 random", 32'(ramp), 32'(exp_ramp(ne, ir)));
         else             chk("R11 random", 32'(ramp), 32'(exp_ramp(ne, ir)));
      end

      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule